// File: doc/BRIEF.md
# Vector Even/Odd Carryless Multiplier

This block multiplies two vectors of `VL` bits lane by lane over GF(2). Each operand is cut into 64-bit lanes. Each lane is read as a polynomial in which bit i is the coefficient of x^i. The two lanes with the same index are multiplied carrylessly: partial products are combined with XOR, so no carry moves between bit positions. Each lane pair gives a 128-bit product.

The products are sorted by the parity of their lane index. Products of lanes 0, 2, 4, … are packed in order into the even destination vector. Products of lanes 1, 3, 5, … are packed in order into the odd destination vector. Each product takes one 128-bit slot. A one-cycle start pulse captures both sources. A single 64×64 multiplier then handles one lane per cycle. A one-cycle done pulse marks the point where both destinations are complete. `VL` may be any power of two from 128 to 2048.

Top module: `vclmul_evenodd`

## Requirements
- R1: For every lane pair, the 128-bit slot holds the carryless product of the two 64-bit source lanes. Output bit j is the XOR over all i of a[i]&b[j-i], with lane bit i standing for x^i.
- R2: Bit 127 of every product slot is zero.
- R3: Bits [128k+127:128k] of `dst_even` hold the product of source lanes 2k, where source lane n is bits [64n+63:64n].
- R4: Bits [128k+127:128k] of `dst_odd` hold the product of source lanes 2k+1.
- R5: Both sources are captured on the clock edge where `start` is accepted. Later changes on `src_a` or `src_b` do not alter the result of that operation.
- R6: After the edge that accepts `start`, `busy` is high and `done` is low. `done` is a single-cycle pulse. It is visible exactly VL/64 clock edges after the accepting edge. `busy` is low from that same point on.
- R7: A `start` that arrives while `busy` is high is ignored. It does not shift the `done` timing, does not change the result, and does not begin a second operation.
- R8: While the block is idle, both destination vectors keep their value whatever the source inputs do.
- R9: While `rst_n` is low, `busy`, `done`, `dst_even` and `dst_odd` are zero. This holds even if reset arrives in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronized inside the block. |
| start | input | 1 | One-cycle request to begin an operation |
| src_a | input | VL | First source vector |
| src_b | input | VL | Second source vector |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: both destinations are final |
| dst_even | output | VL | Products of even-indexed lane pairs |
| dst_odd | output | VL | Products of odd-indexed lane pairs |

## Verification
The bench compares every slot against a reference model. The model sums bit-wise convolution terms instead of shifting the multiplicand, so it does not share the design's method. Tests with all-zero sources and with a multiplier of 1 catch a stuck product and a wrong shift origin. All-ones sources fill the full 127-bit product and push the highest partial product to the top. Single-bit sources at positions 0 and 63 expose off-by-one errors at both ends of the shift range. Sources whose lanes all differ catch swapped lanes, a mixed-up even/odd split and misplaced slots. Further runs change the sources or pulse `start` during an operation, assert reset mid-run, and hold the block idle, to confirm capture, the ignored start and value retention.

// File: rtl/vclmul_pkg.sv
package vclmul_pkg;
  localparam int LANE_W = 64;
  localparam int PROD_W = 2 * LANE_W;
endpackage

// File: rtl/vclmul_core.sv
// 64x64 carryless multiplier: shift-and-XOR over all multiplier bits.
module vclmul_core
  import vclmul_pkg::*;
(
  input  logic [LANE_W-1:0] mcand,
  input  logic [LANE_W-1:0] mplier,
  output logic [PROD_W-1:0] prod
);
  always_comb begin
    prod = '0;
    for (int i = 0; i < LANE_W; i++) begin
      if (mplier[i]) begin
        prod = prod ^ ({{LANE_W{1'b0}}, mcand} << i);
      end
    end
  end
endmodule

// File: rtl/vclmul_seq.sv
// Sequencer: accepts start, walks lane index, emits done.
module vclmul_seq #(
  parameter int LANES = 8,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             load,
  output logic             wr_en,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  assign last  = (idx_q == LAST);
  assign load  = start & ~busy_q;
  assign wr_en = busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign idx  = idx_q;
  assign busy = busy_q;
  assign done = done_q;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_load_begins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && idx_q == '0 && !done_q));
  assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/vclmul_opsel.sv
// Operand capture registers and lane selection.
module vclmul_opsel
  import vclmul_pkg::*;
#(
  parameter int LANES = 8,
  localparam int VL = LANES * LANE_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [VL-1:0]     src_a,
  input  logic [VL-1:0]     src_b,
  input  logic [IDX_W-1:0]  idx,
  output logic [LANE_W-1:0] lane_a,
  output logic [LANE_W-1:0] lane_b
);
  logic [VL-1:0] a_q, a_d;
  logic [VL-1:0] b_q, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (load) begin
      a_d = src_a;
      b_d = src_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign lane_a = a_q[idx*LANE_W +: LANE_W];
  assign lane_b = b_q[idx*LANE_W +: LANE_W];

  assert_operands_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/vclmul_dstbank.sv
// Destination slot registers, steered by lane parity.
module vclmul_dstbank
  import vclmul_pkg::*;
#(
  parameter int LANES = 8,
  localparam int PAIRS = LANES / 2,
  localparam int VL = LANES * LANE_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PROD_W-1:0] prod,
  output logic [VL-1:0]     dst_even,
  output logic [VL-1:0]     dst_odd
);
  for (genvar k = 0; k < PAIRS; k++) begin : g_slot
    logic              ev_en, od_en;
    logic [PROD_W-1:0] ev_q, ev_d, od_q, od_d;

    always_comb begin
      ev_en = wr_en && (idx == IDX_W'(2 * k));
      od_en = wr_en && (idx == IDX_W'(2 * k + 1));
      ev_d  = ev_en ? prod : ev_q;
      od_d  = od_en ? prod : od_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_q <= '0;
        od_q <= '0;
      end else begin
        ev_q <= ev_d;
        od_q <= od_d;
      end
    end

    assign dst_even[k*PROD_W +: PROD_W] = ev_q;
    assign dst_odd[k*PROD_W +: PROD_W]  = od_q;
  end

  assert_prod_top_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !prod[PROD_W-1]);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dst_even) && $stable(dst_odd)));
endmodule

// File: rtl/vclmul_evenodd.sv
module vclmul_evenodd
  import vclmul_pkg::*;
#(
  parameter int VL = 512,
  localparam int LANES = VL / LANE_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VL-1:0] src_a,
  input  logic [VL-1:0] src_b,
  output logic          busy,
  output logic          done,
  output logic [VL-1:0] dst_even,
  output logic [VL-1:0] dst_odd
);
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic              load, wr_en;
  logic [IDX_W-1:0]  idx;
  logic [LANE_W-1:0] lane_a, lane_b;
  logic [PROD_W-1:0] prod;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  vclmul_seq #(.LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .start(start), .load(load),
    .wr_en(wr_en), .idx(idx), .busy(busy), .done(done)
  );

  vclmul_opsel #(.LANES(LANES)) u_opsel (
    .clk(clk), .rst_n(rst_q_n), .load(load), .src_a(src_a), .src_b(src_b),
    .idx(idx), .lane_a(lane_a), .lane_b(lane_b)
  );

  vclmul_core u_core (.mcand(lane_a), .mplier(lane_b), .prod(prod));

  vclmul_dstbank #(.LANES(LANES)) u_dst (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .idx(idx), .prod(prod),
    .dst_even(dst_even), .dst_odd(dst_odd)
  );

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_q_n |-> (!busy && !done && dst_even == '0 && dst_odd == '0));
endmodule

// File: tb/tb_vclmul_evenodd.sv
`timescale 1ns/1ps
module tb_vclmul_evenodd;
  localparam int VL = 512;
  localparam int LANES = VL / 64;
  localparam int PAIRS = LANES / 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [VL-1:0] src_a, src_b;
  logic          busy, done;
  logic [VL-1:0] dst_even, dst_odd;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vclmul_evenodd #(.VL(VL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
    .busy(busy), .done(done), .dst_even(dst_even), .dst_odd(dst_odd)
  );

  // bit-serial convolution reference
  function automatic logic [127:0] ref_clmul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] r;
    r = '0;
    for (int j = 0; j < 127; j++) begin
      for (int i = 0; i < 64; i++) begin
        if ((j - i) >= 0 && (j - i) < 64) r[j] = r[j] ^ (a[i] & b[j - i]);
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_dst(input logic [VL-1:0] a, input logic [VL-1:0] b, input string nm);
    for (int k = 0; k < PAIRS; k++) begin
      logic [127:0] ee, eo, ae, ao;
      ee = ref_clmul(a[128*k +: 64], b[128*k +: 64]);
      eo = ref_clmul(a[128*k+64 +: 64], b[128*k+64 +: 64]);
      ae = dst_even[128*k +: 128];
      ao = dst_odd[128*k +: 128];
      chk(ae == ee, {"R1 R3 even slot ", nm}, ae, ee);
      chk(ao == eo, {"R1 R4 odd slot ", nm}, ao, eo);
      chk(!ae[127] && !ao[127], {"R2 top bit ", nm}, {126'b0, ae[127], ao[127]}, '0);
    end
  endtask

  // mode 0 plain, 1 start pulse while busy, 2 sources changed while busy
  task automatic run_op(input logic [VL-1:0] a, input logic [VL-1:0] b,
                        input int mode, input string nm);
    int cnt;
    @(negedge clk);
    src_a = a; src_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    chk(busy && !done, {"R6 busy after start ", nm}, {126'b0, busy, done}, 128'd2);
    while (!done && cnt < 1000) begin
      @(negedge clk);
      cnt++;
      if (mode == 1 && cnt == 2) begin
        src_a = ~a; src_b = {b[VL-2:0], 1'b1}; start = 1'b1;
      end else if (mode == 1 && cnt == 3) begin
        start = 1'b0;
      end
      if (mode == 2 && cnt == 1) begin
        src_a = ~a; src_b = ~b;
      end
    end
    start = 1'b0;
    chk(cnt == LANES, {"R6 done latency ", nm}, 128'(cnt), 128'(LANES));
    chk(!busy, {"R6 idle at done ", nm}, {127'b0, busy}, '0);
    check_dst(a, b, nm);
    @(negedge clk);
    chk(!done && !busy, {"R6 R7 single pulse, no second run ", nm},
        {126'b0, busy, done}, '0);
  endtask

  function automatic logic [VL-1:0] fill(input logic [63:0] v);
    logic [VL-1:0] r;
    for (int n = 0; n < LANES; n++) r[64*n +: 64] = v;
    return r;
  endfunction

  function automatic logic [VL-1:0] mixed(input logic [63:0] seed);
    logic [VL-1:0] r;
    for (int n = 0; n < LANES; n++)
      r[64*n +: 64] = (seed * 64'(n + 3)) ^ {seed[31:0], seed[63:32]} ^ 64'(n << (7 * n));
    return r;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R9 reset flags", {126'b0, busy, done}, '0);
    chk(dst_even == '0 && dst_odd == '0, "R9 reset destinations", dst_even[127:0], '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_zero();      run_op('0, mixed(64'h1234_5678_9abc_def1), 0, "zero"); endtask
  task automatic t_identity();  run_op(mixed(64'hdead_beef_0bad_f00d), fill(64'd1), 0, "identity"); endtask
  task automatic t_all_ones();  run_op('1, '1, 0, "all ones"); endtask
  task automatic t_bit0();      run_op(fill(64'd1), fill(64'd1), 0, "bit 0"); endtask
  task automatic t_bit63();     run_op(fill(64'h8000_0000_0000_0000), fill(64'h8000_0000_0000_0000), 0, "bit 63"); endtask
  task automatic t_mixed();     run_op(mixed(64'h9e37_79b9_7f4a_7c15), mixed(64'hc2b2_ae3d_27d4_eb4f), 0, "mixed lanes"); endtask
  task automatic t_busy_start(); run_op(mixed(64'h0f0f_1234_aaaa_5555), mixed(64'h7777_0001_8000_fedc), 1, "R7 start while busy"); endtask
  task automatic t_src_change(); run_op(mixed(64'h1357_9bdf_2468_ace0), mixed(64'hfedc_ba98_7654_3210), 2, "R5 sources changed"); endtask

  task automatic t_hold();
    logic [VL-1:0] he, ho;
    he = dst_even; ho = dst_odd;
    src_a = ~src_a; src_b = mixed(64'h5a5a_a5a5_0000_ffff);
    repeat (6) @(negedge clk);
    chk(dst_even == he && dst_odd == ho, "R8 idle hold", dst_even[127:0], he[127:0]);
  endtask

  task automatic t_midrun_reset();
    @(negedge clk);
    src_a = '1; src_b = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy && !done && dst_even == '0 && dst_odd == '0, "R9 mid-run reset",
        {126'b0, busy, done}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    start = 1'b0; src_a = '0; src_b = '0;
    t_reset();
    t_zero();
    t_identity();
    t_all_ones();
    t_bit0();
    t_bit63();
    t_mixed();
    t_hold();
    t_busy_start();
    t_src_change();
    t_midrun_reset();
    t_mixed();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule